// File: doc/BRIEF.md
# Track Segment Sorting Receiver Path

This block is the per-crossing receive path of a sector trigger concentrator. Several input lanes each deliver one track segment candidate word on every bunch crossing. The block checks the parity of each lane and records mismatches in sticky per-lane flags. It drops masked lanes. On request, it replaces live data with generated test words that then travel the same path. It then picks the single best candidate by quality. A programmable number of extra crossings of delay aligns the chosen segment with the rest of the sector.

All lanes arrive already captured as parallel words in one clock domain. One crossing is one clock cycle, and every stage advances on every edge. Two states govern where the data comes from. In MODE_LIVE, lane words come from the input port. In MODE_TEST, they come from the on-chip generator. Two transitions link the states: ENTER_TEST (MODE_LIVE to MODE_TEST when test_en is sampled high) and LEAVE_TEST (MODE_TEST to MODE_LIVE when test_en is sampled low).

Top module: `sc_track_sorter`

## Requirements
- R1: Each 26-bit lane word is laid out as follows: bit 25 is parity, bits 24:22 are quality, bits 21:12 are bend and bits 11:0 are position. A word is good when the XOR of all 26 bits is 0. A word with odd parity on lane c sets perr_flag[c], and that lane counts as empty for selection.
- R2: perr_flag[c] stays set until perr_clr[c] is high at a rising edge. If the same edge also sees a new parity error on lane c, the flag stays set.
- R3: lane_mask[c] is captured together with lane c's word, and a masked lane counts as empty. Masking does not suppress that lane's parity flag.
- R4: Among non-empty lanes, the one with the highest quality is chosen. On equal quality the lowest lane index wins. out_hit is 1 and out_ch gives the chosen lane index.
- R5: A quality of 0 means no segment. When no lane holds a candidate, out_seg is 0, out_ch is 0 and out_hit is 0.
- R6: With delay_bx = 0, a lane word sampled at rising edge k shows on the outputs right after edge k+1. Its parity flag also updates after edge k+1.
- R7: delay_bx = d, with d from 0 to MAX_DLY, holds the chosen result for d more edges. The delay value acts on the output at once. Values above MAX_DLY act as MAX_DLY.
- R8: The mode machine makes ENTER_TEST when test_en is sampled high in MODE_LIVE, and LEAVE_TEST when test_en is sampled low in MODE_TEST. Each edge in MODE_TEST captures generator words instead of lane_data. The generator index n is 0 at the first MODE_TEST capture, increases by 1 each MODE_TEST edge, and returns to 0 in MODE_LIVE. Lane c gets position c*256+n, bend equal to the bitwise inverse of n zero-extended to 10 bits, quality (n+c) mod 8, and an even parity bit. Masks and parity checks apply to these words as to live data.
- R9: After reset, all outputs and flags are 0 and the mode is MODE_LIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data | input | NCH*26 | Lane words; lane c in bits c*26 +: 26 |
| lane_mask | input | NCH | Per-lane mask, 1 = ignore lane |
| test_en | input | 1 | Request for generated test words |
| perr_clr | input | NCH | Per-lane clear of the sticky parity flag |
| delay_bx | input | clog2(MAX_DLY+1) | Extra crossings of output delay |
| out_seg | output | 25 | Chosen segment {quality, bend, position} |
| out_ch | output | clog2(NCH) | Index of the chosen lane |
| out_hit | output | 1 | A segment was chosen |
| perr_flag | output | NCH | Sticky per-lane parity error flags |

## Verification
The bench aims at quality ties across lanes. A sorter that compared with greater-or-equal would report the highest tied index instead of the lowest. Fully empty crossings are also covered: all-zero qualities, fully masked lanes, and a best-quality lane with broken parity. A sorter that left out one of those filters would raise out_hit or pick the corrupt lane. A clear strobe that coincides with a new parity error must leave the flag set, and a design where the clear wins would drop it. The bench also changes the delay on the fly and starts and stops test mode, where a counter that did not restart at 0 or a wrong mode edge would shift every generated word by a crossing.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int POS_W  = 12;
    localparam int BEND_W = 10;
    localparam int QUAL_W = 3;
    localparam int SEG_W  = QUAL_W + BEND_W + POS_W;
    localparam int LANE_W = SEG_W + 1;

    typedef struct packed {
        logic [QUAL_W-1:0] qual;
        logic [BEND_W-1:0] bend;
        logic [POS_W-1:0]  pos;
    } seg_t;

    typedef enum logic {
        MODE_LIVE = 1'b0,
        MODE_TEST = 1'b1
    } mode_e;
endpackage

// File: rtl/sc_lane_src.sv
module sc_lane_src
    import sc_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  test_en,
    input  logic [NCH*LANE_W-1:0] lane_in,
    input  logic [NCH-1:0]        mask_in,
    output logic [NCH*LANE_W-1:0] lane_q,
    output logic [NCH-1:0]        mask_q,
    output mode_e                 mode
);
    mode_e            mode_nxt;
    logic [CNT_W-1:0] gen_n;
    seg_t             pat [NCH];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MODE_LIVE;
        else        mode <= mode_nxt;
    end

    // transitions ENTER_TEST / LEAVE_TEST
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            MODE_LIVE: if (test_en)  mode_nxt = MODE_TEST;
            MODE_TEST: if (!test_en) mode_nxt = MODE_LIVE;
            default:                 mode_nxt = MODE_LIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 gen_n <= '0;
        else if (mode == MODE_TEST) gen_n <= gen_n + 1'b1;
        else                        gen_n <= '0;
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            pat[c].pos  = (POS_W'(c) << CNT_W) | POS_W'(gen_n);
            pat[c].bend = ~BEND_W'(gen_n);
            pat[c].qual = QUAL_W'(gen_n) + QUAL_W'(c);
        end
    end

    // output process: capture live or generated words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            mask_q <= '0;
        end else begin
            mask_q <= mask_in;
            for (int c = 0; c < NCH; c++) begin
                if (mode == MODE_TEST)
                    lane_q[c*LANE_W +: LANE_W] <= {^pat[c], pat[c]};
                else
                    lane_q[c*LANE_W +: LANE_W] <= lane_in[c*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/sc_lane_check.sv
module sc_lane_check
    import sc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*LANE_W-1:0] lane_q,
    input  logic [NCH-1:0]        mask_q,
    input  logic [NCH-1:0]        perr_clr,
    output logic [NCH-1:0]        cand_ok,
    output logic [NCH*SEG_W-1:0]  cand_seg,
    output logic [NCH-1:0]        perr_flag
);
    logic [NCH-1:0] bad;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            bad[c] = ^lane_q[c*LANE_W +: LANE_W];
            cand_seg[c*SEG_W +: SEG_W] = lane_q[c*LANE_W +: SEG_W];
            cand_ok[c] = !mask_q[c] && !bad[c]
                       && (lane_q[c*LANE_W + SEG_W - 1 -: QUAL_W] != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) perr_flag <= '0;
        else        perr_flag <= (perr_flag & ~perr_clr) | bad;
    end
endmodule

// File: rtl/sc_sorter.sv
module sc_sorter
    import sc_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0]          cand_ok,
    input  logic [NCH*SEG_W-1:0]    cand_seg,
    output logic [1+CH_W+SEG_W-1:0] sel_word
);
    logic            pick_hit;
    logic [CH_W-1:0] pick_ch;
    seg_t            pick_seg;
    seg_t            cur;

    // ordered scan: strict greater keeps the lowest index on ties
    always_comb begin
        pick_hit = 1'b0;
        pick_ch  = '0;
        pick_seg = '0;
        cur      = '0;
        for (int c = 0; c < NCH; c++) begin
            cur = cand_seg[c*SEG_W +: SEG_W];
            if (cand_ok[c] && (!pick_hit || cur.qual > pick_seg.qual)) begin
                pick_hit = 1'b1;
                pick_ch  = CH_W'(c);
                pick_seg = cur;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_word <= '0;
        else        sel_word <= {pick_hit, pick_ch, pick_seg};
    end
endmodule

// File: rtl/sc_delay_pipe.sv
module sc_delay_pipe #(
    parameter int W       = 28,
    parameter int MAX_DLY = 7,
    parameter int DLY_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] delay,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);
    localparam int IDX_W = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1;

    logic [W-1:0]     sh [MAX_DLY];
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_DLY; i++) sh[i] <= '0;
        end else begin
            sh[0] <= din;
            for (int i = 1; i < MAX_DLY; i++) sh[i] <= sh[i-1];
        end
    end

    always_comb begin
        if (delay > DLY_W'(MAX_DLY)) idx = IDX_W'(MAX_DLY - 1);
        else                         idx = IDX_W'(delay - 1'b1);
        if (delay == '0) dout = din;
        else             dout = sh[idx];
    end
endmodule

// File: rtl/sc_track_sorter.sv
module sc_track_sorter
    import sc_pkg::*;
#(
    parameter  int NCH     = 4,
    parameter  int MAX_DLY = 7,
    parameter  int CNT_W   = 8,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int DLY_W   = $clog2(MAX_DLY + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH*LANE_W-1:0] lane_data,
    input  logic [NCH-1:0]        lane_mask,
    input  logic                  test_en,
    input  logic [NCH-1:0]        perr_clr,
    input  logic [DLY_W-1:0]      delay_bx,
    output logic [SEG_W-1:0]      out_seg,
    output logic [CH_W-1:0]       out_ch,
    output logic                  out_hit,
    output logic [NCH-1:0]        perr_flag
);
    localparam int OW = 1 + CH_W + SEG_W;

    logic [NCH*LANE_W-1:0] lane_q;
    logic [NCH-1:0]        mask_q;
    mode_e                 mode_w;
    logic [NCH-1:0]        cand_ok;
    logic [NCH*SEG_W-1:0]  cand_seg;
    logic [OW-1:0]         sel_word;
    logic [OW-1:0]         pipe_out;

    sc_lane_src #(.NCH(NCH), .CNT_W(CNT_W)) u_src (
        .clk(clk), .rst_n(rst_n), .test_en(test_en),
        .lane_in(lane_data), .mask_in(lane_mask),
        .lane_q(lane_q), .mask_q(mask_q), .mode(mode_w)
    );

    sc_lane_check #(.NCH(NCH)) u_chk_lane (
        .clk(clk), .rst_n(rst_n), .lane_q(lane_q), .mask_q(mask_q),
        .perr_clr(perr_clr), .cand_ok(cand_ok), .cand_seg(cand_seg),
        .perr_flag(perr_flag)
    );

    sc_sorter #(.NCH(NCH), .CH_W(CH_W)) u_sort (
        .clk(clk), .rst_n(rst_n), .cand_ok(cand_ok), .cand_seg(cand_seg),
        .sel_word(sel_word)
    );

    sc_delay_pipe #(.W(OW), .MAX_DLY(MAX_DLY), .DLY_W(DLY_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .delay(delay_bx),
        .din(sel_word), .dout(pipe_out)
    );

    assign {out_hit, out_ch, out_seg} = pipe_out;
endmodule

// File: rtl/sc_track_sorter_chk.sv
module sc_track_sorter_chk
    import sc_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CH_W  = 2,
    parameter int DLY_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   lane_mask,
    input logic             test_en,
    input logic [NCH-1:0]   perr_clr,
    input logic [DLY_W-1:0] delay_bx,
    input logic [SEG_W-1:0] out_seg,
    input logic [CH_W-1:0]  out_ch,
    input logic             out_hit,
    input logic [NCH-1:0]   perr_flag,
    input mode_e            mode
);
    assert_null_when_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> (out_seg == '0 && out_ch == '0));

    assert_hit_has_quality_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> (out_seg[SEG_W-1 -: QUAL_W] != '0));

    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(perr_flag) & ~$past(perr_clr)) & ~perr_flag) == '0));

    assert_enter_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> mode == MODE_TEST);

    assert_leave_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> mode == MODE_LIVE);

    assert_all_masked_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_bx == '0 && $past(&lane_mask, 2)) |-> !out_hit);
endmodule

bind sc_track_sorter sc_track_sorter_chk #(.NCH(NCH), .CH_W(CH_W), .DLY_W(DLY_W)) u_bound_chk (
    .clk(clk), .rst_n(rst_n), .lane_mask(lane_mask), .test_en(test_en),
    .perr_clr(perr_clr), .delay_bx(delay_bx), .out_seg(out_seg),
    .out_ch(out_ch), .out_hit(out_hit), .perr_flag(perr_flag), .mode(mode_w)
);

// File: tb/sim_sc_track_sorter.sv
module sim_sc_track_sorter;
    import sc_pkg::*;

    localparam int NCH     = 4;
    localparam int MAX_DLY = 7;
    localparam int CH_W    = 2;
    localparam int DLY_W   = 3;
    localparam int OW      = 1 + CH_W + SEG_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [LANE_W-1:0]     drv [NCH];
    logic [NCH*LANE_W-1:0] lane_data;
    logic [NCH-1:0]        lane_mask, perr_clr, perr_flag;
    logic                  test_en, out_hit;
    logic [DLY_W-1:0]      delay_bx;
    logic [SEG_W-1:0]      out_seg;
    logic [CH_W-1:0]       out_ch;

    int checks = 0;
    int errors = 0;

    always_comb begin
        for (int c = 0; c < NCH; c++) lane_data[c*LANE_W +: LANE_W] = drv[c];
    end

    sc_track_sorter #(.NCH(NCH), .MAX_DLY(MAX_DLY)) u0 (
        .clk(clk), .rst_n(rst_n), .lane_data(lane_data), .lane_mask(lane_mask),
        .test_en(test_en), .perr_clr(perr_clr), .delay_bx(delay_bx),
        .out_seg(out_seg), .out_ch(out_ch), .out_hit(out_hit), .perr_flag(perr_flag)
    );

    // expected-value helpers
    function automatic seg_t gen_seg(int c, logic [7:0] n);
        seg_t s;
        s.pos  = {c[3:0], n};
        s.bend = ~{2'b00, n};
        s.qual = 3'((int'(n) + c) % 8);
        return s;
    endfunction

    function automatic logic [LANE_W-1:0] make_lane(seg_t s, bit corrupt);
        return {(^s) ^ corrupt, s};
    endfunction

    function automatic logic [OW-1:0] ref_pick(input logic [LANE_W-1:0] l [NCH],
                                               input logic [NCH-1:0] m);
        int top = 0;
        int who = -1;
        for (int c = 0; c < NCH; c++) begin
            if (!m[c] && !(^l[c]) && int'(l[c][SEG_W-1 -: QUAL_W]) > top)
                top = int'(l[c][SEG_W-1 -: QUAL_W]);
        end
        for (int c = NCH - 1; c >= 0; c--) begin
            if (top != 0 && !m[c] && !(^l[c]) && int'(l[c][SEG_W-1 -: QUAL_W]) == top)
                who = c;
        end
        if (who < 0) return '0;
        return {1'b1, CH_W'(who), l[who][SEG_W-1:0]};
    endfunction

    // reference timing model built from R6, R7, R8
    logic              m_mode;
    logic [7:0]        m_n;
    logic [LANE_W-1:0] m_lane [NCH];
    logic [NCH-1:0]    m_mask, m_perr;
    logic [OW-1:0]     m_sel;
    logic [OW-1:0]     m_hist [MAX_DLY];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 1'b0; m_n <= '0; m_mask <= '0; m_perr <= '0; m_sel <= '0;
            for (int c = 0; c < NCH; c++) m_lane[c] <= '0;
            for (int i = 0; i < MAX_DLY; i++) m_hist[i] <= '0;
        end else begin
            m_mode <= test_en;
            m_n    <= m_mode ? m_n + 8'd1 : 8'd0;
            for (int c = 0; c < NCH; c++)
                m_lane[c] <= m_mode ? make_lane(gen_seg(c, m_n), 1'b0) : drv[c];
            m_mask <= lane_mask;
            m_sel  <= ref_pick(m_lane, m_mask);
            for (int c = 0; c < NCH; c++)
                m_perr[c] <= (^m_lane[c]) ? 1'b1 : (perr_clr[c] ? 1'b0 : m_perr[c]);
            m_hist[0] <= m_sel;
            for (int i = 1; i < MAX_DLY; i++) m_hist[i] <= m_hist[i-1];
        end
    end

    task automatic check_now(string tag, string ftag);
        logic [OW-1:0] e, a;
        int d;
        d = int'(delay_bx);
        if (d > MAX_DLY) d = MAX_DLY;
        e = (d == 0) ? m_sel : m_hist[d-1];
        a = {out_hit, out_ch, out_seg};
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s output actual=%h expected=%h", tag, a, e);
        end
        checks++;
        if (perr_flag !== m_perr) begin
            errors++;
            $display("FAIL %s perr_flag actual=%b expected=%b", ftag, perr_flag, m_perr);
        end
    endtask

    task automatic fill_lanes(int bad_pct, int qmode);
        logic [2:0] tq;
        seg_t s;
        tq = 3'($urandom_range(7, 1));
        for (int c = 0; c < NCH; c++) begin
            s.pos  = 12'($urandom);
            s.bend = 10'($urandom);
            case (qmode)
                1:       s.qual = tq;
                2:       s.qual = 3'd0;
                default: s.qual = 3'($urandom);
            endcase
            drv[c] = make_lane(s, int'($urandom_range(99, 0)) < bad_pct);
        end
    endtask

    task automatic step(string tag, string ftag);
        @(negedge clk);
        check_now(tag, ftag);
    endtask

    initial begin
        seg_t one;
        void'($urandom(32'd7151));
        for (int c = 0; c < NCH; c++) drv[c] = '0;
        lane_mask = '0; perr_clr = '0; test_en = 1'b0; delay_bx = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        checks++;
        if ({out_hit, out_ch, out_seg, perr_flag} !== '0) begin
            errors++;
            $display("FAIL R9 reset outputs actual=%h expected=0", {out_hit, out_ch, out_seg, perr_flag});
        end
        rst_n = 1'b1;
        step("R9", "R9");

        // R4: random qualities, good parity
        for (int i = 0; i < 60; i++) begin fill_lanes(0, 0); step("R4", "R1"); end
        // R4: ties across all lanes
        for (int i = 0; i < 20; i++) begin fill_lanes(0, 1); step("R4", "R1"); end
        // R5: all qualities zero
        for (int i = 0; i < 10; i++) begin fill_lanes(0, 2); step("R5", "R1"); end
        // R3: random masks, then everything masked
        for (int i = 0; i < 40; i++) begin
            fill_lanes(10, 0); lane_mask = 4'($urandom); step("R3", "R3");
        end
        for (int i = 0; i < 10; i++) begin
            fill_lanes(0, 0); lane_mask = '1; step("R3", "R3");
        end
        lane_mask = '0;
        // R1: parity errors with random clears
        for (int i = 0; i < 40; i++) begin
            fill_lanes(25, 1); perr_clr = 4'($urandom & 32'h5); step("R1", "R2");
        end
        // R2: directed sticky, set-wins and clear
        perr_clr = '1; fill_lanes(0, 0); step("R2", "R2");
        perr_clr = '0;
        one = '0; one.qual = 3'd7; one.pos = 12'h123;
        drv[2] = make_lane(one, 1'b1); step("R2", "R2");
        fill_lanes(0, 0);
        for (int i = 0; i < 4; i++) step("R2", "R2");
        checks++;
        if (perr_flag[2] !== 1'b1) begin
            errors++; $display("FAIL R2 sticky flag actual=%b expected=1", perr_flag[2]);
        end
        drv[2] = make_lane(one, 1'b1); perr_clr = 4'b0100; step("R2", "R2");
        fill_lanes(0, 0); step("R2", "R2");
        perr_clr = '0; step("R2", "R2");
        checks++;
        if (perr_flag[2] !== 1'b1) begin
            errors++; $display("FAIL R2 set-wins flag actual=%b expected=1", perr_flag[2]);
        end
        perr_clr = 4'b0100; step("R2", "R2");
        perr_clr = '0; step("R2", "R2");
        checks++;
        if (perr_flag[2] !== 1'b0) begin
            errors++; $display("FAIL R2 clear flag actual=%b expected=0", perr_flag[2]);
        end
        // R6: one directed word, delay 0, appears after exactly one more edge
        for (int c = 0; c < NCH; c++) drv[c] = '0;
        step("R6", "R6");
        one = '0; one.qual = 3'd5; one.bend = 10'h2AA; one.pos = 12'hABC;
        drv[1] = make_lane(one, 1'b0);
        @(negedge clk);
        drv[1] = '0;
        checks++;
        if (out_hit !== 1'b0) begin
            errors++; $display("FAIL R6 early output actual=%b expected=0", out_hit);
        end
        @(negedge clk);
        checks++;
        if ({out_hit, out_ch, out_seg} !== {1'b1, 2'd1, one}) begin
            errors++;
            $display("FAIL R6 latency actual=%h expected=%h", {out_hit, out_ch, out_seg}, {1'b1, 2'd1, one});
        end
        // R7: delay changes on the fly
        for (int i = 0; i < 60; i++) begin
            fill_lanes(5, 0); delay_bx = 3'($urandom); step("R7", "R1");
        end
        delay_bx = 3'd7;
        for (int i = 0; i < 10; i++) begin fill_lanes(0, 0); step("R7", "R1"); end
        delay_bx = '0;
        // R8: test mode entry, run, exit
        test_en = 1'b1;
        for (int i = 0; i < 30; i++) begin
            fill_lanes(50, 0); lane_mask = (i > 15) ? 4'($urandom) : 4'd0; step("R8", "R8");
        end
        test_en = 1'b0; lane_mask = '0;
        for (int i = 0; i < 6; i++) begin fill_lanes(0, 0); step("R8", "R8"); end
        test_en = 1'b1;
        for (int i = 0; i < 12; i++) begin fill_lanes(0, 2); step("R8", "R8"); end
        test_en = 1'b0;
        for (int i = 0; i < 6; i++) begin fill_lanes(0, 0); step("R8", "R8"); end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog R6 run did not complete actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule